// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Reads and writes may follow each other on consecutive clock edges with no idle cycle between them. Each word holds two 9-bit bytes. The depth is set by the address-width parameter. The data path is split into an input bus, an output bus and an output-valid flag.

Every access starts with a load cycle. On that cycle the address, the three chip selects and the read/write select are captured. The following advance cycles step through the rest of a four-beat burst. A 2-bit counter inside the block forms the low two address bits, in either linear or interleaved order.

In pipelined mode, read data appears two enabled edges after its command. Write data is taken at the same distance after its command. In flow-through mode, both distances shrink to one edge. Because write data trails its command by the read latency, the bus never has to turn around.

Top module: `zt_sram`

## Requirements
- R1: While `cke_n` is high, a clock edge has no effect. No command is taken, no write commits, and the burst state, pipeline stages and output all hold their values.
- R2: On an enabled edge with `adv_ld` low, a new access is loaded. The address and the selects are captured. `rd_wr_n`=1 makes it a read and `rd_wr_n`=0 makes it a write.
- R3: On an enabled edge with `adv_ld` high, `rd_wr_n`, `cs0_n`, `cs1`, `cs2_n` and `addr` are ignored. The access continues with the operation of the last load at the next burst address.
- R4: With `burst_ilv`=0, beat n of a burst has low address bits (start+n) mod 4. The upper address bits stay at the loaded value, and the order wraps after four beats.
- R5: With `burst_ilv`=1, beat n of a burst has low address bits start XOR (n mod 4). The upper bits are fixed.
- R6: Byte enables are active low. `bw_n[0]` gates `din[8:0]` and `bw_n[1]` gates `din[17:9]`. They are sampled on the edge of each write beat's command, for loads and advances alike.
- R7: With `pipe_mode`=1, read data is presented after the second enabled edge following the read command. Write data is taken from `din` on that second enabled edge.
- R8: With `pipe_mode`=0, read data is presented after the first enabled edge following the command. Write data is taken on that first enabled edge.
- R9: A read may directly follow a write to the same address. It returns the newly written bytes, merged with the old contents of any byte whose write was masked.
- R10: A load is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A deselected load ends any burst. Advances after it issue no beats, and the output goes idle at the read latency.
- R11: `dout_en` is high only while a read beat's data is presented and `oe_n` is low. `oe_n` acts without waiting for a clock edge. While `dout_en` is low, `dout` is zero.
- R12: While `sleep` is high, edges are ignored exactly as in R1, and the memory contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low |
| adv_ld | input | 1 | 0 = load new access, 1 = advance burst |
| rd_wr_n | input | 1 | At load: 1 = read, 0 = write |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| bw_n | input | 2 | Per-byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through |
| sleep | input | 1 | Stops all operation, contents kept |
| addr | input | ADDR_W | Word address |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, zero when not valid |
| dout_en | output | 1 | Read data valid and output enabled |

## Verification
Two functions can fall in the same edge. In pipelined mode, the data phase of a write commits on the very edge that captures the data of a read issued one cycle later. When both target the same word, the read must see the incoming bytes. The bench provokes this with directed write-then-read pairs to one address under full and partial byte masks, and then with long random command streams over both burst orders and both latencies. A behavioural reference model commits the write before it forms the read data, and the output is compared with that model on every cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  localparam int unsigned BYTE_W  = 9;
  localparam int unsigned NBYTE   = 2;
  localparam int unsigned WORD_W  = BYTE_W * NBYTE;
  localparam int unsigned BURST_W = 2;

  // control part of one issued beat
  typedef struct packed {
    logic             vld;
    logic             rd;
    logic [NBYTE-1:0] be;
  } beat_ctl_t;

  // low address bits of a burst beat
  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               ilv
  );
    burst_offset = ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_burst_ctrl.sv
module zt_burst_ctrl
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              rd_req,
  input  logic              sel_ok,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [NBYTE-1:0]  be_in,
  input  logic              ilv,
  output beat_ctl_t         beat_ctl,
  output logic [ADDR_W-1:0] beat_addr
);

  logic               act_q, act_d;
  logic               rd_q, rd_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] idx_q, idx_d;

  always_comb begin
    act_d  = act_q;
    rd_d   = rd_q;
    base_d = base_q;
    idx_d  = idx_q + {{(BURST_W-1){1'b0}}, 1'b1};
    if (load) begin
      act_d  = sel_ok;
      rd_d   = rd_req;
      base_d = addr_in;
      idx_d  = '0;
    end
  end

  always_comb begin
    beat_ctl.vld = load ? sel_ok : act_q;
    beat_ctl.rd  = load ? rd_req : rd_q;
    beat_ctl.be  = be_in;
    if (load) begin
      beat_addr = addr_in;
    end else begin
      beat_addr = {base_q[ADDR_W-1:BURST_W],
                   burst_offset(base_q[BURST_W-1:0], idx_d, ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
    end else if (en) begin
      act_q  <= act_d;
      rd_q   <= rd_d;
      base_q <= base_d;
      idx_q  <= idx_d;
    end
  end

  a_r1_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(act_q) && $stable(base_q) && $stable(idx_q) && $stable(rd_q)));

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (base_q == $past(addr_in) && idx_q == '0 && rd_q == $past(rd_req)));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> (idx_q == $past(idx_q) + 2'd1 && $stable(base_q)));

  a_r10_deselect_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load && !sel_ok) |=> !act_q);

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NBYTE-1:0]  wbe,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[b]) begin
        lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
      end
    end

    assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
  end

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  beat_ctl_t         beat_ctl,
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [NBYTE-1:0]  wbe,
  output logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);

  beat_ctl_t         s1_ctl, s2_ctl, wr_ctl;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic              rd_v_q, rd_v_d;
  logic [WORD_W-1:0] rd_data_q, rd_data_d;
  logic [WORD_W-1:0] fwd_word;
  logic              fwd_hit;
  logic              out_v;
  logic [WORD_W-1:0] out_d;

  // write port: data phase one or two stages behind the command
  always_comb begin
    wr_ctl = pipe_mode ? s2_ctl : s1_ctl;
    waddr  = pipe_mode ? s2_addr : s1_addr;
    we     = en && wr_ctl.vld && !wr_ctl.rd;
    wbe    = wr_ctl.be;
    wdata  = din;
    raddr  = s1_addr;
  end

  // same-edge write into the word being captured for a read
  assign fwd_hit = s2_ctl.vld && !s2_ctl.rd && (s2_addr == s1_addr);

  for (genvar b = 0; b < NBYTE; b++) begin : g_fwd
    assign fwd_word[b*BYTE_W +: BYTE_W] = (fwd_hit && s2_ctl.be[b]) ?
        din[b*BYTE_W +: BYTE_W] : rdata[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rd_v_d    = rd_v_q;
    rd_data_d = rd_data_q;
    if (en) begin
      rd_v_d    = s1_ctl.vld && s1_ctl.rd;
      rd_data_d = fwd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ctl    <= '0;
      s1_addr   <= '0;
      s2_ctl    <= '0;
      s2_addr   <= '0;
      rd_v_q    <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_v_q    <= rd_v_d;
      rd_data_q <= rd_data_d;
      if (en) begin
        s1_ctl  <= beat_ctl;
        s1_addr <= beat_addr;
        s2_ctl  <= s1_ctl;
        s2_addr <= s1_addr;
      end
    end
  end

  // output select and asynchronous gating
  always_comb begin
    out_v   = pipe_mode ? rd_v_q : (s1_ctl.vld && s1_ctl.rd);
    out_d   = pipe_mode ? rd_data_q : rdata;
    dout_en = out_v && !oe_n;
    dout    = dout_en ? out_d : '0;
  end

  a_r8_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pipe_mode && beat_ctl.vld && beat_ctl.rd) |=> (pipe_mode || dout_en == !oe_n));

  a_r7_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pipe_mode && s1_ctl.vld && s1_ctl.rd) |=> (!pipe_mode || dout_en == !oe_n));

  a_r9_same_edge_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_ctl.vld && !s2_ctl.rd && (&s2_ctl.be) && s1_ctl.vld && s1_ctl.rd
     && s2_addr == s1_addr) |=> (rd_data_q == $past(din)));

  a_r12_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(s1_addr) && $stable(s1_ctl) && $stable(rd_data_q) && $stable(rd_v_q)));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              adv_ld,
  input  logic              rd_wr_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic [NBYTE-1:0]  bw_n,
  input  logic              oe_n,
  input  logic              burst_ilv,
  input  logic              pipe_mode,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);

  logic              en;
  logic              sel_ok;
  beat_ctl_t         beat_ctl;
  logic [ADDR_W-1:0] beat_addr;
  logic [ADDR_W-1:0] raddr, waddr;
  logic              we;
  logic [NBYTE-1:0]  wbe;
  logic [WORD_W-1:0] wdata, rdata;

  assign en     = !cke_n && !sleep;
  assign sel_ok = !cs0_n && cs1 && !cs2_n;

  zt_burst_ctrl #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load      (!adv_ld),
    .rd_req    (rd_wr_n),
    .sel_ok    (sel_ok),
    .addr_in   (addr),
    .be_in     (~bw_n),
    .ilv       (burst_ilv),
    .beat_ctl  (beat_ctl),
    .beat_addr (beat_addr)
  );

  zt_sram_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pipe_mode (pipe_mode),
    .oe_n      (oe_n),
    .beat_ctl  (beat_ctl),
    .beat_addr (beat_addr),
    .din       (din),
    .rdata     (rdata),
    .raddr     (raddr),
    .we        (we),
    .waddr     (waddr),
    .wbe       (wbe),
    .wdata     (wdata),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  zt_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wbe   (wbe),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  a_r11_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_en && dout == '0));

endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  import zt_sram_pkg::*;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cke_n, adv_ld, rd_wr_n, cs0_n, cs1, cs2_n;
  logic [NBYTE-1:0]  bw_n;
  logic              oe_n, burst_ilv, pipe_mode, sleep;
  logic [AW-1:0]     addr;
  logic [WORD_W-1:0] din;
  logic [WORD_W-1:0] dout;
  logic              dout_en;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    checking = 0;
  bit    done = 0;
  string cur_req = "R11";

  always #5 clk = ~clk;

  zt_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld), .rd_wr_n(rd_wr_n),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .bw_n(bw_n), .oe_n(oe_n),
    .burst_ilv(burst_ilv), .pipe_mode(pipe_mode), .sleep(sleep), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  // ---------------- reference model ----------------
  logic [WORD_W-1:0] mm [DEPTH];
  int m_act, m_rd, m_base, m_n;
  int h_v [3];
  int h_rd[3];
  int h_a [3];
  int h_be[3];
  int exp_v;
  logic [WORD_W-1:0] exp_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_rd = 0; m_base = 0; m_n = 0; exp_v = 0; exp_d = '0;
      for (int i = 0; i < 3; i++) begin
        h_v[i] = 0; h_rd[i] = 0; h_a[i] = 0; h_be[i] = 0;
      end
    end else if (!cke_n && !sleep) begin : m_step
      int nv, nrd, na, d, o;
      if (!adv_ld) begin
        nv = (!cs0_n && cs1 && !cs2_n) ? 1 : 0;
        nrd = int'(rd_wr_n);
        m_act = nv; m_rd = nrd; m_base = int'(addr); m_n = 0;
        na = int'(addr);
      end else begin
        m_n = (m_n + 1) % 4;
        nv = m_act; nrd = m_rd;
        na = (m_base & ~3) |
             (burst_ilv ? ((m_base & 3) ^ m_n) : (((m_base & 3) + m_n) % 4));
      end
      for (int i = 2; i > 0; i--) begin
        h_v[i] = h_v[i-1]; h_rd[i] = h_rd[i-1]; h_a[i] = h_a[i-1]; h_be[i] = h_be[i-1];
      end
      h_v[0] = nv; h_rd[0] = nrd; h_a[0] = na; h_be[0] = int'(~bw_n) & 3;
      d = pipe_mode ? 2 : 1;
      if (h_v[d] != 0 && h_rd[d] == 0) begin
        for (int b = 0; b < NBYTE; b++)
          if (h_be[d][b]) mm[h_a[d]][b*BYTE_W +: BYTE_W] = din[b*BYTE_W +: BYTE_W];
      end
      o = pipe_mode ? 1 : 0;
      exp_v = (h_v[o] != 0 && h_rd[o] != 0) ? 1 : 0;
      exp_d = mm[h_a[o]];
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && checking && !done) begin : cmp
      logic              e_en;
      logic [WORD_W-1:0] e_out;
      e_en  = (exp_v != 0) && !oe_n;
      e_out = e_en ? exp_d : '0;
      n_chk++;
      if (dout_en !== e_en || dout !== e_out) begin
        n_fail++;
        $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                 cur_req, dout_en, dout, e_en, e_out);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic sel_on();
    cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
  endtask

  task automatic cmd_load(input logic rd, input logic [AW-1:0] a, input logic [1:0] bwn);
    adv_ld = 1'b0; rd_wr_n = rd; sel_on(); addr = a; bw_n = bwn;
    din = WORD_W'($urandom);
    tick();
  endtask

  // selects, rd_wr_n and addr are scrambled: advances must ignore them (R3)
  task automatic cmd_adv(input logic [1:0] bwn);
    adv_ld = 1'b1; rd_wr_n = 1'($urandom); cs0_n = 1'($urandom);
    cs1 = 1'($urandom); cs2_n = 1'($urandom); addr = AW'($urandom);
    bw_n = bwn; din = WORD_W'($urandom);
    tick();
  endtask

  task automatic cmd_desel();
    adv_ld = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    rd_wr_n = 1'b1; din = WORD_W'($urandom);
    tick();
  endtask

  task automatic drain();
    cke_n = 1'b0; sleep = 1'b0; oe_n = 1'b0;
    repeat (4) cmd_desel();
  endtask

  task automatic directed_suite();
    cur_req = "R2";
    cmd_load(1'b1, 8'h05, 2'b11);
    cmd_load(1'b1, 8'h06, 2'b11);
    cmd_load(1'b0, 8'h07, 2'b00);
    cmd_load(1'b1, 8'h07, 2'b11);
    cur_req = "R9";
    cmd_load(1'b0, 8'h11, 2'b00);
    cmd_load(1'b1, 8'h11, 2'b11);
    cmd_load(1'b0, 8'h12, 2'b10);
    cmd_load(1'b1, 8'h12, 2'b11);
    cmd_load(1'b0, 8'h13, 2'b01);
    cmd_load(1'b1, 8'h13, 2'b11);
    cmd_desel();
    cur_req = "R6";
    cmd_load(1'b0, 8'h09, 2'b10);
    cmd_load(1'b0, 8'h09, 2'b01);
    cmd_load(1'b0, 8'h09, 2'b11);
    cmd_load(1'b1, 8'h09, 2'b11);
    cmd_load(1'b0, 8'h30, 2'b00);
    cmd_adv(2'b10); cmd_adv(2'b01); cmd_adv(2'b11);
    cmd_load(1'b1, 8'h30, 2'b11);
    repeat (3) cmd_adv(2'b11);
    cur_req = "R4";
    burst_ilv = 1'b0;
    cmd_load(1'b0, 8'h21, 2'b00);
    repeat (3) cmd_adv(2'b00);
    cmd_load(1'b1, 8'h21, 2'b11);
    repeat (7) cmd_adv(2'b11);
    cmd_load(1'b1, 8'h7F, 2'b11);
    repeat (4) cmd_adv(2'b11);
    cur_req = "R5";
    burst_ilv = 1'b1;
    cmd_load(1'b0, 8'h42, 2'b00);
    repeat (3) cmd_adv(2'b00);
    cmd_load(1'b1, 8'h42, 2'b11);
    repeat (3) cmd_adv(2'b11);
    cmd_load(1'b1, 8'h43, 2'b11);
    repeat (5) cmd_adv(2'b11);
    burst_ilv = 1'b0;
    cur_req = "R3";
    cmd_load(1'b0, 8'h50, 2'b00);
    repeat (3) cmd_adv(2'b00);
    cmd_load(1'b1, 8'h50, 2'b11);
    repeat (3) cmd_adv(2'b11);
    cur_req = "R10";
    cmd_load(1'b1, 8'h60, 2'b11);
    cmd_adv(2'b11);
    cmd_desel();
    cmd_adv(2'b11); cmd_adv(2'b00); cmd_adv(2'b11);
    adv_ld = 1'b0; cs0_n = 1'b0; cs1 = 1'b0; cs2_n = 1'b0; tick();
    adv_ld = 1'b0; cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b1; tick();
    cmd_adv(2'b11);
    cur_req = "R11";
    cmd_load(1'b1, 8'h64, 2'b11);
    oe_n = 1'b1; cmd_adv(2'b11);
    oe_n = 1'b0; cmd_adv(2'b11);
    oe_n = 1'b1; cmd_adv(2'b11);
    oe_n = 1'b0; cmd_desel(); cmd_desel();
    cur_req = "R1";
    cmd_load(1'b1, 8'h70, 2'b11);
    cmd_adv(2'b11);
    cke_n = 1'b1;
    cmd_load(1'b0, 8'h70, 2'b00);
    cmd_adv(2'b00);
    cmd_desel();
    cke_n = 1'b0;
    cmd_adv(2'b11); cmd_adv(2'b11);
    cur_req = "R12";
    cmd_load(1'b1, 8'h74, 2'b11);
    sleep = 1'b1;
    cmd_load(1'b0, 8'h74, 2'b00);
    cmd_load(1'b0, 8'h75, 2'b00);
    cmd_adv(2'b00);
    sleep = 1'b0;
    cmd_adv(2'b11); cmd_adv(2'b11); cmd_adv(2'b11);
    cmd_desel(); cmd_desel();
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      cke_n   = ($urandom_range(0, 9) == 0);
      sleep   = ($urandom_range(0, 19) == 0);
      oe_n    = ($urandom_range(0, 4) == 0);
      burst_ilv = burst_ilv;
      adv_ld  = ($urandom_range(0, 9) < 6);
      rd_wr_n = 1'($urandom);
      if ($urandom_range(0, 9) < 8) sel_on();
      else begin cs0_n = 1'($urandom); cs1 = 1'($urandom); cs2_n = 1'b1; end
      addr = AW'($urandom_range(0, 15)) | (AW'($urandom_range(0, 1)) << 6);
      bw_n = 2'($urandom);
      din  = WORD_W'($urandom);
      tick();
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; cke_n = 1'b0; adv_ld = 1'b0; rd_wr_n = 1'b1;
    cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1; bw_n = 2'b11; oe_n = 1'b0;
    burst_ilv = 1'b0; pipe_mode = 1'b0; sleep = 1'b0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (dout_en !== 1'b0 || dout !== '0) begin
      n_fail++;
      $display("FAIL R11 reset: dout_en=%0b dout=%h expected dout_en=0 dout=0", dout_en, dout);
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    checking = 1;

    // fill every word so later reads never see unwritten locations
    cur_req = "R8";
    for (int a = 0; a < DEPTH; a++) cmd_load(1'b0, AW'(a), 2'b00);
    cmd_load(1'b1, 8'h00, 2'b11);
    cmd_load(1'b1, 8'hFF, 2'b11);
    drain();

    cur_req = "R8";
    directed_suite();
    cur_req = "R8";
    random_run(1500);
    burst_ilv = 1'b1;
    random_run(1500);

    drain();
    pipe_mode = 1'b1;
    burst_ilv = 1'b0;
    cur_req = "R7";
    cmd_load(1'b1, 8'h05, 2'b11);
    cmd_desel(); cmd_desel();
    directed_suite();
    cur_req = "R7";
    random_run(1500);
    burst_ilv = 1'b1;
    random_run(1500);
    drain();

    done = 1;
    summary();
    $finish;
  end

endmodule